// File: doc/BRIEF.md
# Fixed-Point Convolution Sum-of-Products Unit

This unit computes one output sample of a single-feature-map convolution for each 7x7 window of a three-channel image. Before any image data, it receives the convolution kernel as a stream of bytes: 147 signed Q0.15 coefficients, each sent as two bytes. After the kernel is complete, the unit accepts windows from an upstream line buffer. Each window carries all 147 unsigned 8-bit pixels at once.

Each pixel is zero-extended to a signed 9-bit value and multiplied by its coefficient. The unit has seven multipliers. Each cycle it processes one window row of one channel, so a window takes 21 multiply cycles. The products are summed in a full-precision accumulator. The total is then rounded half-up to drop 15 fractional bits and clamped to a signed 16-bit result. While a window is being processed, the unit holds its ready output low, which stalls the window source.

The controller is a four-state machine:
- KLOAD collects kernel bytes. It moves to WAIT once the last byte is stored.
- WAIT signals ready. It moves to MAC when a window is accepted.
- MAC runs the 21 row/channel steps. It moves to EMIT after the last step.
- EMIT registers the rounded result and strobes it. It then returns to WAIT.

An active-low reset returns the machine to KLOAD.

Top module: `conv_sop_unit`

## Requirements
- R1: The kernel arrives as 294 bytes. Coefficient k = (row*7+col)*3+chan comes as two bytes, high byte first, in ascending k. `win_ready` stays low until the last of these bytes has been taken on a `kbyte_valid` cycle.
- R2: Kernel bytes that arrive after loading is complete do not change the stored kernel or any later result.
- R3: Pixel k of a window sits at `win_pixels[8k+7:8k]`, uses the same index as the coefficient, and is treated as unsigned 0..255.
- R4: `result` equals floor((S + 2^14) / 2^15), clamped to the range -32768..32767. S is the exact sum over k of pixel_k*coef_k.
- R5: Each accepted window (`win_valid` high while `win_ready` is high at a clock edge) produces exactly one `result_valid` pulse, one cycle wide.
- R6: `result_valid` rises 22 clock edges after the accepting edge. In between, `busy` is high and `win_ready` is low.
- R7: The accumulator holds every partial sum exactly, so the extreme kernels and pixels still saturate correctly and never wrap.
- R8: After reset, `win_ready`, `busy` and `result_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| kbyte_valid | input | 1 | Kernel byte strobe |
| kbyte_data | input | 8 | Kernel byte |
| win_valid | input | 1 | Window offered by the line buffer |
| win_pixels | input | 1176 | 147 pixels, pixel k in bits 8k+7..8k |
| win_ready | output | 1 | Unit can accept a window |
| busy | output | 1 | Window being processed |
| result_valid | output | 1 | One-cycle strobe for a new result |
| result | output | 16 | Rounded, saturated signed result |

## Verification
Random Q0.15 kernels are combined with random windows, all-zero windows and all-255 windows. Together these show that the pixel and coefficient indices line up and that pixels are never sign-extended.

Kernels filled entirely with 0x7FFF or 0x8000, applied to all-255 windows, drive the sum past both output limits. These cases separate correct clamping from accumulator wrap.

A sparse kernel with single pixels placed at index 0, 1 and 146 lands exactly on the half-LSB points. These cases separate round-half-up from truncation or symmetric rounding, and also confirm the high-byte-first order.

Extra kernel bytes sent after loading, followed by a window checked against the original kernel, show that reloading is blocked.

// File: rtl/conv_sop_pkg.sv
package conv_sop_pkg;
    localparam int KROWS_D  = 7;
    localparam int KCOLS_D  = 7;
    localparam int KCH_D    = 3;
    localparam int PIX_W_D  = 8;
    localparam int COEF_W_D = 16;
    localparam int OUT_W_D  = 16;
    localparam int FRAC_D   = 15;

    typedef enum logic [1:0] {
        ST_KLOAD,
        ST_WAIT,
        ST_MAC,
        ST_EMIT
    } sop_state_t;
endpackage

// File: rtl/conv_kernel_store.sv
module conv_kernel_store #(
    parameter int TAPS   = 147,
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     byte_valid,
    input  logic [7:0]               byte_data,
    output logic                     loaded,
    output logic [TAPS*COEF_W-1:0]   coef_flat
);
    localparam int NBYTES = 2 * TAPS;
    localparam int CNT_W  = $clog2(NBYTES + 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [7:0]        hi_q;
    logic              loaded_q;
    logic [COEF_W-1:0] coef_q [TAPS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            hi_q     <= '0;
            loaded_q <= 1'b0;
        end else if (byte_valid && !loaded_q) begin
            if (!cnt_q[0]) begin
                hi_q <= byte_data;
            end
            cnt_q    <= cnt_q + 1'b1;
            loaded_q <= (cnt_q == CNT_W'(NBYTES - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst_n && byte_valid && !loaded_q && cnt_q[0]) begin
            coef_q[cnt_q[CNT_W-1:1]] <= COEF_W'({hi_q, byte_data});
        end
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_flat
        assign coef_flat[g*COEF_W +: COEF_W] = coef_q[g];
    end

    assign loaded = loaded_q;

    AST_LOAD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_q |-> (cnt_q == CNT_W'(NBYTES)));  // R1
    AST_LOAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_q |=> (loaded_q && $stable(cnt_q)));  // R2
endmodule

// File: rtl/conv_row_mac.sv
module conv_row_mac #(
    parameter int KCOLS  = 7,
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16,
    parameter int SUM_W  = 28
) (
    input  logic [KCOLS*PIX_W-1:0]  pix_flat,
    input  logic [KCOLS*COEF_W-1:0] coef_flat,
    output logic signed [SUM_W-1:0] row_sum
);
    localparam int PROD_W = PIX_W + 1 + COEF_W;

    logic signed [PROD_W-1:0] prod [KCOLS];

    for (genvar g = 0; g < KCOLS; g++) begin : g_mul
        logic signed [PIX_W:0]    pix_s;
        logic signed [COEF_W-1:0] coef_s;
        assign pix_s   = $signed({1'b0, pix_flat[g*PIX_W +: PIX_W]});
        assign coef_s  = $signed(coef_flat[g*COEF_W +: COEF_W]);
        assign prod[g] = pix_s * coef_s;
    end

    always_comb begin
        row_sum = '0;
        for (int i = 0; i < KCOLS; i++) begin
            row_sum = row_sum + {{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
        end
    end
endmodule

// File: rtl/conv_round_sat.sv
module conv_round_sat #(
    parameter int ACC_W = 33,
    parameter int FRAC  = 15,
    parameter int OUT_W = 16
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] res
);
    localparam int EW = ACC_W + 1;
    localparam logic signed [EW-1:0] HALF =
        {{(EW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
    localparam logic signed [EW-1:0] SAT_HI =
        {{(EW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EW-1:0] SAT_LO =
        {{(EW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [EW-1:0] biased;
    logic signed [EW-1:0] shifted;

    always_comb begin
        biased  = $signed({acc[ACC_W-1], acc}) + HALF;
        shifted = biased >>> FRAC;
        if (shifted > SAT_HI) begin
            res = {1'b0, {(OUT_W-1){1'b1}}};
        end else if (shifted < SAT_LO) begin
            res = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            res = shifted[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/conv_sop_unit.sv
module conv_sop_unit
    import conv_sop_pkg::*;
#(
    parameter int KROWS  = KROWS_D,
    parameter int KCOLS  = KCOLS_D,
    parameter int KCH    = KCH_D,
    parameter int PIX_W  = PIX_W_D,
    parameter int COEF_W = COEF_W_D,
    parameter int OUT_W  = OUT_W_D,
    parameter int FRAC   = FRAC_D
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 kbyte_valid,
    input  logic [7:0]                           kbyte_data,
    input  logic                                 win_valid,
    input  logic [KROWS*KCOLS*KCH*PIX_W-1:0]     win_pixels,
    output logic                                 win_ready,
    output logic                                 busy,
    output logic                                 result_valid,
    output logic signed [OUT_W-1:0]              result
);
    localparam int TAPS   = KROWS * KCOLS * KCH;
    localparam int PROD_W = PIX_W + 1 + COEF_W;
    localparam int SUM_W  = PROD_W + $clog2(KCOLS);
    localparam int ACC_W  = PROD_W + $clog2(TAPS);
    localparam int ROW_W  = $clog2(KROWS);
    localparam int CH_W   = $clog2(KCH);
    localparam longint ACC_LIMIT =
        longint'(TAPS) * ((longint'(1) << PIX_W) - 1) * (longint'(1) << (COEF_W - 1));

    sop_state_t state_q, state_d;

    logic                       k_loaded;
    logic [TAPS*COEF_W-1:0]     coef_all;
    logic [TAPS*PIX_W-1:0]      win_q;
    logic [ROW_W-1:0]           row_q;
    logic [CH_W-1:0]            ch_q;
    logic signed [ACC_W-1:0]    acc_q;
    logic [KCOLS*PIX_W-1:0]     pix_sel;
    logic [KCOLS*COEF_W-1:0]    coef_sel;
    logic signed [SUM_W-1:0]    row_sum;
    logic signed [OUT_W-1:0]    rounded;
    logic signed [OUT_W-1:0]    result_q;
    logic                       valid_q;
    logic                       accept;
    logic                       last_step;

    conv_kernel_store #(.TAPS(TAPS), .COEF_W(COEF_W)) u_kstore (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (kbyte_valid),
        .byte_data  (kbyte_data),
        .loaded     (k_loaded),
        .coef_flat  (coef_all)
    );

    always_comb begin
        for (int c = 0; c < KCOLS; c++) begin
            int idx;
            idx = (int'(row_q) * KCOLS + c) * KCH + int'(ch_q);
            pix_sel[c*PIX_W +: PIX_W]    = win_q[idx*PIX_W +: PIX_W];
            coef_sel[c*COEF_W +: COEF_W] = coef_all[idx*COEF_W +: COEF_W];
        end
    end

    conv_row_mac #(.KCOLS(KCOLS), .PIX_W(PIX_W), .COEF_W(COEF_W), .SUM_W(SUM_W)) u_mac (
        .pix_flat  (pix_sel),
        .coef_flat (coef_sel),
        .row_sum   (row_sum)
    );

    conv_round_sat #(.ACC_W(ACC_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_round (
        .acc (acc_q),
        .res (rounded)
    );

    assign accept    = win_valid && (state_q == ST_WAIT);
    assign last_step = (row_q == ROW_W'(KROWS - 1)) && (ch_q == CH_W'(KCH - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_KLOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_KLOAD: if (k_loaded)  state_d = ST_WAIT;
            ST_WAIT:  if (win_valid) state_d = ST_MAC;
            ST_MAC:   if (last_step) state_d = ST_EMIT;
            ST_EMIT:                 state_d = ST_WAIT;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            ch_q     <= '0;
            acc_q    <= '0;
            win_q    <= '0;
            result_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state_q)
                ST_KLOAD: ;
                ST_WAIT: begin
                    if (accept) begin
                        win_q <= win_pixels;
                        acc_q <= '0;
                        row_q <= '0;
                        ch_q  <= '0;
                    end
                end
                ST_MAC: begin
                    acc_q <= acc_q + {{(ACC_W-SUM_W){row_sum[SUM_W-1]}}, row_sum};
                    if (ch_q == CH_W'(KCH - 1)) begin
                        ch_q  <= '0;
                        row_q <= row_q + 1'b1;
                    end else begin
                        ch_q <= ch_q + 1'b1;
                    end
                end
                ST_EMIT: begin
                    result_q <= rounded;
                    valid_q  <= 1'b1;
                end
            endcase
        end
    end

    assign win_ready    = (state_q == ST_WAIT);
    assign busy         = (state_q == ST_MAC) || (state_q == ST_EMIT);
    assign result_valid = valid_q;
    assign result       = result_q;

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);  // R5
    AST_BUSY_BLOCKS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !win_ready);  // R6
    AST_ACCEPT_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_ready) |=> busy);  // R6
    AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (longint'(acc_q) <= ACC_LIMIT) && (longint'(acc_q) >= -ACC_LIMIT));  // R7
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !acc_q[ACC_W-1]) |-> !result[OUT_W-1]);  // R4
    AST_NO_READY_BEFORE_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_KLOAD) |-> (!win_ready && !busy));  // R1
endmodule

// File: tb/conv_sop_unit_tb_top.sv
module conv_sop_unit_tb_top;
    localparam int TAPS = 147;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   kbyte_valid = 1'b0;
    logic [7:0]             kbyte_data = '0;
    logic                   win_valid = 1'b0;
    logic [TAPS*8-1:0]      win_pixels = '0;
    logic                   win_ready;
    logic                   busy;
    logic                   result_valid;
    logic signed [15:0]     result;

    int checks = 0;
    int errors = 0;

    logic [15:0] kern [TAPS];
    logic [7:0]  pix  [TAPS];

    always #5 clk = ~clk;

    conv_sop_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .kbyte_valid  (kbyte_valid),
        .kbyte_data   (kbyte_data),
        .win_valid    (win_valid),
        .win_pixels   (win_pixels),
        .win_ready    (win_ready),
        .busy         (busy),
        .result_valid (result_valid),
        .result       (result)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint ref_out();
        longint s = 0;
        for (int i = 0; i < TAPS; i++) begin
            s += longint'(pix[i]) * longint'($signed(kern[i]));
        end
        s = (s + 16384) >>> 15;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; kbyte_valid = 1'b0; win_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!win_ready && !busy && !result_valid, "R8 reset outputs",
            {win_ready, busy, result_valid}, 0);
    endtask

    task automatic send_byte(input logic [7:0] b);
        kbyte_valid = 1'b1; kbyte_data = b;
        @(negedge clk);
        kbyte_valid = 1'b0;
        if ($urandom % 3 == 0) @(negedge clk);
    endtask

    task automatic load_kernel();
        for (int i = 0; i < TAPS; i++) begin
            send_byte(kern[i][15:8]);
            if (i < TAPS - 1) send_byte(kern[i][7:0]);
        end
        repeat (3) @(negedge clk);
        chk(!win_ready, "R1 ready held before last byte", win_ready, 0);
        send_byte(kern[TAPS-1][7:0]);
        repeat (2) @(negedge clk);
        chk(win_ready, "R1 ready after full kernel", win_ready, 1);
    endtask

    task automatic run_window(input string tag);
        longint exp;
        int lat;
        for (int i = 0; i < TAPS; i++) win_pixels[i*8 +: 8] = pix[i];
        exp = ref_out();
        while (!win_ready) @(negedge clk);
        win_valid = 1'b1;
        @(negedge clk);
        win_valid = 1'b0;
        chk(busy && !win_ready, "R6 busy after accept", {busy, win_ready}, 2);
        lat = 0;
        while (!result_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 22, "R6 latency", lat, 22);
        chk(result == exp, tag, result, exp);
        @(negedge clk);
        chk(!result_valid, "R5 single strobe", result_valid, 0);
    endtask

    task automatic fill_pix(input int mode);
        for (int i = 0; i < TAPS; i++) begin
            case (mode)
                0: pix[i] = 8'd0;
                1: pix[i] = 8'd255;
                default: pix[i] = 8'($urandom);
            endcase
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();

        // random kernel, several window patterns: R1 R3 R4
        for (int i = 0; i < TAPS; i++) kern[i] = 16'($urandom);
        load_kernel();
        fill_pix(0); run_window("R4 zero window");
        fill_pix(1); run_window("R3 all-255 unsigned window");
        for (int n = 0; n < 8; n++) begin
            fill_pix(2); run_window("R4 random window");
        end

        // late kernel bytes ignored: R2
        for (int n = 0; n < 12; n++) send_byte(8'($urandom));
        fill_pix(2); run_window("R2 kernel unchanged after extra bytes");

        // positive saturation: R7
        do_reset();
        for (int i = 0; i < TAPS; i++) kern[i] = 16'h7FFF;
        load_kernel();
        fill_pix(1); run_window("R7 positive clamp");

        // negative saturation: R7
        do_reset();
        for (int i = 0; i < TAPS; i++) kern[i] = 16'h8000;
        load_kernel();
        fill_pix(1); run_window("R7 negative clamp");

        // rounding and index placement: R4 R3 R1
        do_reset();
        for (int i = 0; i < TAPS; i++) kern[i] = 16'h0000;
        kern[0] = 16'h0080; kern[1] = 16'hFF80; kern[TAPS-1] = 16'h0100;
        load_kernel();
        fill_pix(0); pix[0] = 8'd128;        run_window("R4 half rounds up to 1");
        fill_pix(0); pix[1] = 8'd128;        run_window("R4 minus half rounds to 0");
        fill_pix(0); pix[1] = 8'd129;        run_window("R4 below minus half gives -1");
        fill_pix(0); pix[TAPS-1] = 8'd64;    run_window("R3 last index placement");
        fill_pix(0); pix[2] = 8'd255;        run_window("R1 zero coefficient slot");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule